// File: doc/BRIEF.md
# Fused Multiply-Add Special-Operand Resolver

This block sits at the front of a single-precision fused multiply-add unit that computes either z + x·y or z − x·y. It sorts each of the three 32-bit operands into one of six classes: zero, denormal, normal, infinity, quiet NaN or signaling NaN. From these classes it decides whether the final answer is already fixed by the special-value rules, without any arithmetic.

When the answer is fixed, the block raises `bypass`, presents the finished 32-bit word on `result` and reports any invalid-operation condition. When no rule applies, it raises `compute`, and the downstream multiply, align, add and round datapath produces the result. Rounding, denormal normalization and the arithmetic itself belong to that datapath. The decision is combinational and is registered once, with `out_valid` following `in_valid` by one cycle.

The sign of the product is its effective sign, `sign(x) ^ sign(y)`, which is inverted when `negate_prod` is 1. The rounding-mode encoding is 00 to nearest, 01 toward zero, 10 toward +infinity and 11 toward −infinity.

Top module: `fma_special_resolve`

## Requirements
- R1: Each operand is classified by its fields, with exponent [30:23] and fraction [22:0]. An all-ones exponent with a zero fraction is infinity. An all-ones exponent with fraction bit 22 set is a quiet NaN. An all-ones exponent with bit 22 clear and a nonzero fraction is a signaling NaN. A zero exponent with a nonzero fraction is a denormal, and it is treated as a nonzero finite value.
- R2: If any operand is a signaling NaN, the result is the first signaling NaN in the order z, x, y, with fraction bit 22 set to quiet it. `invalid` is 1. This rule takes priority over every quiet NaN.
- R3: If no operand is a signaling NaN but at least one is a quiet NaN, the result is the first quiet NaN in the order z, x, y, returned bit for bit. `invalid` is 0.
- R4: An infinity multiplied by a zero, in either order and whatever z is (other than a NaN), returns the default NaN 32'h7FC00000 with `invalid` = 1.
- R5: An infinite product with an infinite z of the opposite sign to the effective product sign returns the default NaN with `invalid` = 1.
- R6: In every other case an infinite product returns infinity carrying the effective product sign, with `invalid` = 0.
- R7: A zero product (the other factor finite) with z infinite or nonzero finite returns z unchanged.
- R8: A zero product with a zero z returns z when z's sign equals the effective product sign. Otherwise it returns zero, which is negative only when `round_mode` is 2'b11.
- R9: A finite nonzero product with an infinite z returns z's infinity.
- R10: When none of R2 to R9 applies, `compute` is 1, `bypass` is 0, `invalid` is 0 and `result` is 0.
- R11: Outputs are registered. The cycle after `in_valid` is 1, `out_valid` is 1 and the outputs show that operation. The cycle after `in_valid` is 0, `out_valid` is 0 and the other outputs hold their values. A reset clears all outputs to 0.
- R12: While `out_valid` is 1, exactly one of `bypass` and `compute` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Operands on the inputs are to be resolved |
| negate_prod | input | 1 | 1 selects z − x·y |
| round_mode | input | 2 | 00 nearest, 01 to zero, 10 to +inf, 11 to −inf |
| addend | input | 32 | Operand z |
| mul_a | input | 32 | Operand x |
| mul_b | input | 32 | Operand y |
| out_valid | output | 1 | Registered outputs belong to an accepted operation |
| bypass | output | 1 | Result is final |
| compute | output | 1 | Datapath must compute the result |
| invalid | output | 1 | Invalid-operation flag |
| result | output | 32 | Final result when bypass is 1, otherwise 0 |

## Verification
The checker assumes that `in_valid` is held low during reset. It also assumes that the operand inputs are stable at the clock edge at which `in_valid` is sampled, because its NaN properties decode the operand inputs one cycle ahead of the registered flags. The bench drives every input on the falling edge and keeps `in_valid` low throughout reset, so both assumptions hold. The stimulus covers signaling and quiet NaNs in each operand position, both signs of every infinity and zero, and denormals in each position.

// File: rtl/fma_sr_pkg.sv
// Shared types for the FMA special-operand resolver.
// Assumes binary32-style layout: sign, exponent, fraction from MSB down.
package fma_sr_pkg;

    typedef enum logic [2:0] {
        CLS_ZERO   = 3'd0,
        CLS_DENORM = 3'd1,
        CLS_NORMAL = 3'd2,
        CLS_INF    = 3'd3,
        CLS_QNAN   = 3'd4,
        CLS_SNAN   = 3'd5
    } opclass_e;

    // Rounding-mode code for round toward minus infinity
    localparam logic [1:0] RM_TOWARD_NEG = 2'b11;

    // Operand slots in priority order for NaN selection
    localparam int SLOT_Z   = 0;
    localparam int SLOT_X   = 1;
    localparam int SLOT_Y   = 2;
    localparam int NUM_OPS  = 3;

endpackage

// File: rtl/fma_sr_classify.sv
// Classifies one floating-point operand by its exponent and fraction fields.
// Assumes the fraction MSB distinguishes quiet (1) from signaling (0) NaNs.
module fma_sr_classify
    import fma_sr_pkg::*;
#(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23,
    localparam int WORD_W = 1 + EXP_W + FRAC_W
) (
    input  logic [WORD_W-1:0] operand,
    output opclass_e          cls
);

    logic [EXP_W-1:0]  exp_f;
    logic [FRAC_W-1:0] frac_f;

    assign exp_f  = operand[WORD_W-2 -: EXP_W];
    assign frac_f = operand[FRAC_W-1:0];

    // Decode class from field patterns
    always_comb begin
        if (exp_f == '1) begin
            if (frac_f == '0)
                cls = CLS_INF;
            else if (frac_f[FRAC_W-1])
                cls = CLS_QNAN;
            else
                cls = CLS_SNAN;
        end else if (exp_f == '0) begin
            cls = (frac_f == '0) ? CLS_ZERO : CLS_DENORM;
        end else begin
            cls = CLS_NORMAL;
        end
    end

endmodule

// File: rtl/fma_sr_nan_select.sv
// Picks the NaN that propagates: all signaling NaNs outrank all quiet NaNs,
// and within each group operand slot 0 outranks 1, which outranks 2.
// Assumes slots are ordered z, x, y by the caller.
module fma_sr_nan_select
    import fma_sr_pkg::*;
#(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23,
    localparam int WORD_W = 1 + EXP_W + FRAC_W
) (
    input  logic [NUM_OPS-1:0][WORD_W-1:0] ops,
    input  opclass_e                        cls [NUM_OPS],
    output logic                            nan_hit,
    output logic                            nan_invalid,
    output logic [WORD_W-1:0]               nan_word
);

    logic [NUM_OPS-1:0] is_snan;
    logic [NUM_OPS-1:0] is_qnan;

    for (genvar g = 0; g < NUM_OPS; g++) begin : g_flag
        assign is_snan[g] = (cls[g] == CLS_SNAN);
        assign is_qnan[g] = (cls[g] == CLS_QNAN);
    end

    // Priority scan: highest slot first so the lowest slot wins last
    always_comb begin
        nan_hit     = 1'b0;
        nan_invalid = 1'b0;
        nan_word    = '0;
        if (is_snan != '0) begin
            nan_hit     = 1'b1;
            nan_invalid = 1'b1;
            for (int i = NUM_OPS - 1; i >= 0; i--) begin
                if (is_snan[i]) begin
                    nan_word             = ops[i];
                    nan_word[FRAC_W-1]   = 1'b1;
                end
            end
        end else if (is_qnan != '0) begin
            nan_hit = 1'b1;
            for (int i = NUM_OPS - 1; i >= 0; i--) begin
                if (is_qnan[i])
                    nan_word = ops[i];
            end
        end
    end

endmodule

// File: rtl/fma_sr_special_decide.sv
// Resolves infinity and zero cases of z +/- x*y once NaNs are excluded.
// Assumes no operand is a NaN (caller gives NaN selection priority).
module fma_sr_special_decide
    import fma_sr_pkg::*;
#(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23,
    localparam int WORD_W = 1 + EXP_W + FRAC_W,
    parameter logic [WORD_W-1:0] DEFAULT_NAN = 32'h7FC0_0000
) (
    input  opclass_e          cls_z,
    input  opclass_e          cls_x,
    input  opclass_e          cls_y,
    input  logic [WORD_W-1:0] z_word,
    input  logic              sign_x,
    input  logic              sign_y,
    input  logic              negate,
    input  logic [1:0]        rmode,
    output logic              spec_hit,
    output logic              spec_invalid,
    output logic [WORD_W-1:0] spec_word
);

    logic prod_sign;
    logic sign_z;
    logic x_inf, y_inf, x_zero, y_zero, z_inf, z_zero;

    assign prod_sign = sign_x ^ sign_y ^ negate;
    assign sign_z    = z_word[WORD_W-1];
    assign x_inf     = (cls_x == CLS_INF);
    assign y_inf     = (cls_y == CLS_INF);
    assign x_zero    = (cls_x == CLS_ZERO);
    assign y_zero    = (cls_y == CLS_ZERO);
    assign z_inf     = (cls_z == CLS_INF);
    assign z_zero    = (cls_z == CLS_ZERO);

    // Case split on the product class, then on the addend
    always_comb begin
        spec_hit     = 1'b0;
        spec_invalid = 1'b0;
        spec_word    = '0;
        if ((x_inf && y_zero) || (x_zero && y_inf)) begin
            spec_hit     = 1'b1;
            spec_invalid = 1'b1;
            spec_word    = DEFAULT_NAN;
        end else if (x_inf || y_inf) begin
            spec_hit = 1'b1;
            if (z_inf && (sign_z != prod_sign)) begin
                spec_invalid = 1'b1;
                spec_word    = DEFAULT_NAN;
            end else begin
                spec_word = {prod_sign, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
            end
        end else if (x_zero || y_zero) begin
            spec_hit = 1'b1;
            if (z_zero && (sign_z != prod_sign))
                spec_word = {(rmode == RM_TOWARD_NEG), {(WORD_W-1){1'b0}}};
            else
                spec_word = z_word;
        end else if (z_inf) begin
            spec_hit  = 1'b1;
            spec_word = z_word;
        end
    end

endmodule

// File: rtl/fma_special_resolve.sv
// Top of the FMA special-operand resolver. Classifies z, x, y, merges the
// NaN and infinity/zero decisions, and registers the outcome with a valid.
// Assumes in_valid is low during reset; data registers load only on in_valid.
module fma_special_resolve
    import fma_sr_pkg::*;
#(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23,
    localparam int WORD_W = 1 + EXP_W + FRAC_W,
    parameter logic [WORD_W-1:0] DEFAULT_NAN = 32'h7FC0_0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              negate_prod,
    input  logic [1:0]        round_mode,
    input  logic [WORD_W-1:0] addend,
    input  logic [WORD_W-1:0] mul_a,
    input  logic [WORD_W-1:0] mul_b,
    output logic              out_valid,
    output logic              bypass,
    output logic              compute,
    output logic              invalid,
    output logic [WORD_W-1:0] result
);

    logic [NUM_OPS-1:0][WORD_W-1:0] ops;
    opclass_e                       cls [NUM_OPS];

    logic              nan_hit, nan_invalid;
    logic [WORD_W-1:0] nan_word;
    logic              spec_hit, spec_invalid;
    logic [WORD_W-1:0] spec_word;

    logic              nxt_bypass, nxt_invalid;
    logic [WORD_W-1:0] nxt_result;

    assign ops[SLOT_Z] = addend;
    assign ops[SLOT_X] = mul_a;
    assign ops[SLOT_Y] = mul_b;

    for (genvar g = 0; g < NUM_OPS; g++) begin : g_cls
        fma_sr_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_cls (
            .operand (ops[g]),
            .cls     (cls[g])
        );
    end

    fma_sr_nan_select #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_nan (
        .ops         (ops),
        .cls         (cls),
        .nan_hit     (nan_hit),
        .nan_invalid (nan_invalid),
        .nan_word    (nan_word)
    );

    fma_sr_special_decide #(
        .EXP_W(EXP_W), .FRAC_W(FRAC_W), .DEFAULT_NAN(DEFAULT_NAN)
    ) u_dec (
        .cls_z        (cls[SLOT_Z]),
        .cls_x        (cls[SLOT_X]),
        .cls_y        (cls[SLOT_Y]),
        .z_word       (addend),
        .sign_x       (mul_a[WORD_W-1]),
        .sign_y       (mul_b[WORD_W-1]),
        .negate       (negate_prod),
        .rmode        (round_mode),
        .spec_hit     (spec_hit),
        .spec_invalid (spec_invalid),
        .spec_word    (spec_word)
    );

    // NaN outcome outranks the infinity/zero outcome
    always_comb begin
        if (nan_hit) begin
            nxt_bypass  = 1'b1;
            nxt_invalid = nan_invalid;
            nxt_result  = nan_word;
        end else begin
            nxt_bypass  = spec_hit;
            nxt_invalid = spec_invalid;
            nxt_result  = spec_word;
        end
    end

    // Output register stage with synchronous active-low reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            bypass    <= 1'b0;
            compute   <= 1'b0;
            invalid   <= 1'b0;
            result    <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                bypass  <= nxt_bypass;
                compute <= !nxt_bypass;
                invalid <= nxt_invalid;
                result  <= nxt_result;
            end
        end
    end

endmodule

// File: rtl/fma_sr_checker.sv
// Property checker for fma_special_resolve, bound to every instance.
// Assumes operands are stable at the edge where in_valid is sampled.
module fma_sr_checker #(
    parameter int WORD_W = 32,
    parameter int FRAC_W = 23
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [WORD_W-1:0] addend,
    input logic [WORD_W-1:0] mul_a,
    input logic [WORD_W-1:0] mul_b,
    input logic              out_valid,
    input logic              bypass,
    input logic              compute,
    input logic              invalid,
    input logic [WORD_W-1:0] result
);

    localparam int EXP_W = WORD_W - 1 - FRAC_W;

    function automatic logic chk_snan(input logic [WORD_W-1:0] w);
        return (w[WORD_W-2 -: EXP_W] == '1) && !w[FRAC_W-1] && (w[FRAC_W-2:0] != '0);
    endfunction

    function automatic logic chk_qnan(input logic [WORD_W-1:0] w);
        return (w[WORD_W-2 -: EXP_W] == '1) && w[FRAC_W-1];
    endfunction

    logic any_snan, any_qnan;
    assign any_snan = chk_snan(addend) || chk_snan(mul_a) || chk_snan(mul_b);
    assign any_qnan = chk_qnan(addend) || chk_qnan(mul_a) || chk_qnan(mul_b);

    AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $onehot({bypass, compute})); // R12

    AST_COMPUTE_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        compute |-> (!invalid && result == '0)); // R10

    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid); // R11

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && $stable(result) && $stable(invalid))); // R11

    AST_SNAN_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && any_snan) |=> (invalid && bypass && result[WORD_W-2 -: EXP_W+1] == '1)); // R2

    AST_QNAN_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !any_snan && any_qnan) |=> (!invalid && bypass)); // R3

endmodule

bind fma_special_resolve fma_sr_checker #(.WORD_W(WORD_W), .FRAC_W(FRAC_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .addend    (addend),
    .mul_a     (mul_a),
    .mul_b     (mul_b),
    .out_valid (out_valid),
    .bypass    (bypass),
    .compute   (compute),
    .invalid   (invalid),
    .result    (result)
);

// File: tb/tb_fma_special_resolve.sv
// Self-checking bench: table walk, then directed reset and idle tests.
module tb_fma_special_resolve;

    localparam time CLK_PERIOD = 10ns;
    localparam int  WATCHDOG   = 5000;

    typedef struct packed {
        logic [31:0] z;
        logic [31:0] x;
        logic [31:0] y;
        logic        neg;
        logic [1:0]  rm;
        logic        byp;
        logic        inv;
        logic [31:0] res;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 26;
    localparam vec_t VEC [NV] = '{
        '{32'h7F800005, 32'h7F800009, 32'h7FC00001, 1'b0, 2'b00, 1'b1, 1'b1, 32'h7FC00005, 8'd2},  // R2 z first
        '{32'h7FC00003, 32'h7FA00000, 32'h3F800000, 1'b0, 2'b00, 1'b1, 1'b1, 32'h7FE00000, 8'd2},  // R2 sNaN beats qNaN
        '{32'h3F800000, 32'h7FC00007, 32'hFF800002, 1'b0, 2'b00, 1'b1, 1'b1, 32'hFFC00002, 8'd2},  // R2 y sNaN
        '{32'h3F800000, 32'h3F800000, 32'h7FBFFFFF, 1'b0, 2'b00, 1'b1, 1'b1, 32'h7FFFFFFF, 8'd1},  // R1 sNaN field pattern
        '{32'hFFC00005, 32'h7FC00009, 32'h3F800000, 1'b0, 2'b00, 1'b1, 1'b0, 32'hFFC00005, 8'd3},  // R3 z first
        '{32'h3F800000, 32'h40000000, 32'h7FC00011, 1'b0, 2'b00, 1'b1, 1'b0, 32'h7FC00011, 8'd3},  // R3 y qNaN
        '{32'h3F800000, 32'h7F800000, 32'h00000000, 1'b0, 2'b00, 1'b1, 1'b1, 32'h7FC00000, 8'd4},  // R4
        '{32'h7F800000, 32'h80000000, 32'h7F800000, 1'b0, 2'b00, 1'b1, 1'b1, 32'h7FC00000, 8'd4},  // R4 zero*inf
        '{32'hFF800000, 32'h7F800000, 32'h40000000, 1'b0, 2'b00, 1'b1, 1'b1, 32'h7FC00000, 8'd5},  // R5
        '{32'hFF800000, 32'h7F800000, 32'h40000000, 1'b1, 2'b00, 1'b1, 1'b0, 32'hFF800000, 8'd6},  // R6 negate matches
        '{32'h3F800000, 32'hFF800000, 32'h40000000, 1'b0, 2'b00, 1'b1, 1'b0, 32'hFF800000, 8'd6},  // R6
        '{32'h3F800000, 32'hFF800000, 32'hFF800000, 1'b1, 2'b00, 1'b1, 1'b0, 32'hFF800000, 8'd6},  // R6 negated
        '{32'h7F800000, 32'h00000001, 32'h7F800000, 1'b0, 2'b00, 1'b1, 1'b0, 32'h7F800000, 8'd6},  // R6 denormal factor
        '{32'hFF800000, 32'h00000000, 32'h40000000, 1'b0, 2'b00, 1'b1, 1'b0, 32'hFF800000, 8'd7},  // R7 z inf
        '{32'hBF800000, 32'h40000000, 32'h00000000, 1'b0, 2'b00, 1'b1, 1'b0, 32'hBF800000, 8'd7},  // R7 z finite
        '{32'h80000003, 32'h00000000, 32'h00000000, 1'b0, 2'b00, 1'b1, 1'b0, 32'h80000003, 8'd7},  // R7 z denormal
        '{32'h00000000, 32'h00000000, 32'h80000000, 1'b0, 2'b00, 1'b1, 1'b0, 32'h00000000, 8'd8},  // R8 differ, nearest
        '{32'h00000000, 32'h00000000, 32'h80000000, 1'b0, 2'b11, 1'b1, 1'b0, 32'h80000000, 8'd8},  // R8 differ, down
        '{32'h80000000, 32'h80000000, 32'h00000000, 1'b0, 2'b00, 1'b1, 1'b0, 32'h80000000, 8'd8},  // R8 match
        '{32'h00000000, 32'h00000000, 32'h00000000, 1'b1, 2'b11, 1'b1, 1'b0, 32'h80000000, 8'd8},  // R8 negated differ
        '{32'h00000000, 32'h00000000, 32'h00000000, 1'b1, 2'b10, 1'b1, 1'b0, 32'h00000000, 8'd8},  // R8 toward +inf
        '{32'hFF800000, 32'h3F800000, 32'h00400000, 1'b0, 2'b00, 1'b1, 1'b0, 32'hFF800000, 8'd9},  // R9
        '{32'h7F800000, 32'hC0000000, 32'h3F800000, 1'b0, 2'b00, 1'b1, 1'b0, 32'h7F800000, 8'd9},  // R9
        '{32'h3F800000, 32'h40000000, 32'h3F800000, 1'b0, 2'b00, 1'b0, 1'b0, 32'h00000000, 8'd10}, // R10
        '{32'h00000000, 32'h00000001, 32'h40000000, 1'b0, 2'b00, 1'b0, 1'b0, 32'h00000000, 8'd10}, // R10 z zero
        '{32'h80000003, 32'h3F800000, 32'h3F800000, 1'b1, 2'b00, 1'b0, 1'b0, 32'h00000000, 8'd10}  // R10 z denormal
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        negate_prod = 1'b0;
    logic [1:0]  round_mode = 2'b00;
    logic [31:0] addend = '0, mul_a = '0, mul_b = '0;
    logic        out_valid, bypass, compute, invalid;
    logic [31:0] result;

    int n_checks = 0;
    int n_fails  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fma_special_resolve dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .negate_prod(negate_prod), .round_mode(round_mode),
        .addend(addend), .mul_a(mul_a), .mul_b(mul_b),
        .out_valid(out_valid), .bypass(bypass), .compute(compute),
        .invalid(invalid), .result(result)
    );

    task automatic check(input string tag, input logic [35:0] act, input logic [35:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Packs {out_valid, bypass, compute, invalid, result} for one compare
    function automatic logic [35:0] outs();
        return {out_valid, bypass, compute, invalid, result};
    endfunction

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [31:0] held;
        repeat (3) @(negedge clk);
        check("R11 reset state", outs(), 36'h0);
        rst_n = 1'b1;

        // Table walk: drive at a falling edge, sample at the next falling edge
        for (int i = 0; i < NV; i++) begin
            addend      = VEC[i].z;
            mul_a       = VEC[i].x;
            mul_b       = VEC[i].y;
            negate_prod = VEC[i].neg;
            round_mode  = VEC[i].rm;
            in_valid    = 1'b1;
            @(negedge clk);
            check($sformatf("R%0d/R12 vector %0d", VEC[i].req, i), outs(),
                  {1'b1, VEC[i].byp, !VEC[i].byp, VEC[i].inv, VEC[i].res});
        end

        // R11: idle cycle holds data and drops valid, even if operands change
        held        = result;
        in_valid    = 1'b0;
        addend      = 32'h7F800001;
        @(negedge clk);
        check("R11 idle hold", outs(), {1'b0, 1'b0, 1'b1, 1'b0, held});

        // R11: back-to-back bypass then reset mid-stream
        addend   = 32'hFF800000;
        mul_a    = 32'h3F800000;
        mul_b    = 32'h3F800000;
        in_valid = 1'b1;
        @(negedge clk);
        check("R9 directed", outs(), {1'b1, 1'b1, 1'b0, 1'b0, 32'hFF800000});
        rst_n    = 1'b0;
        in_valid = 1'b0;
        @(negedge clk);
        check("R11 reset clears", outs(), 36'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R11 after reset idle", outs(), 36'h0);

        finish_run();
    end

endmodule